// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block watches both lines of an open-drain, wired-AND two-wire serial bus (clock line and data line, both idle high, either pulled low by any device) and reports bus-level conditions to a controller that shares it. It finds START conditions, where the data line falls while the clock line is high. It finds STOP conditions, where the data line rises while the clock line is high. From these it keeps a busy level that runs from a START to the next STOP.

It also checks arbitration. When the local driver has released the data line, it expects to read back a high level. If the bus reads low at a rising clock edge instead, another device is driving, and the monitor sets a sticky arbitration-lost flag. The flag stays set until the controller clears it with a write-one-to-clear strobe.

Both raw lines pass through a synchronizer of `SYNC_STAGES` flops. Each synchronized level is compared with its previous sample to find edges. The monitor drives no line.

Top module: `busCondMon`

## Requirements
- R1: During and after reset, `startPulse`, `stopPulse`, `busBusy` and `arbLost` are all 0. `busBusy` stays 0 until the first START.
- R2: A fall of `sdaIn` while `sclIn` stays high gives `startPulse` = 1 for exactly one cycle. With the default 2 synchronizer stages, the pulse appears on the third rising clock edge after the input change.
- R3: A rise of `sdaIn` while `sclIn` stays high gives `stopPulse` = 1 for exactly one cycle, with the same latency as R2.
- R4: `busBusy` goes to 1 with `startPulse`, goes to 0 with `stopPulse`, and otherwise holds its value. A repeated START keeps it at 1, and a STOP while idle leaves it at 0.
- R5: A change of `sdaIn` while `sclIn` is low gives no pulse and leaves `busBusy` unchanged.
- R6: A change of `sdaIn` in the same synchronized sample as a change of `sclIn` is not a START or STOP. No pulse results and `busBusy` is unchanged.
- R7: On a rising edge of the synchronized clock line, if `sdaDriveLow` = 0 (local driver released) and the synchronized data line is 0, `arbLost` becomes 1 and stays 1.
- R8: `arbLost` is not set by a rising clock edge while `sdaDriveLow` = 1, nor while the data line is high. It is also not set by a low data line without a rising clock edge.
- R9: `arbClear` = 1 clears `arbLost` on the next clock edge. If a set condition from R7 occurs in the same cycle, the flag ends up set.
- R10: `startPulse` and `stopPulse` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw clock line level |
| sdaIn | input | 1 | Raw data line level |
| sdaDriveLow | input | 1 | 1 when the local driver pulls the data line low, 0 when released |
| arbClear | input | 1 | Write-one-to-clear strobe for the arbitration flag |
| startPulse | output | 1 | One-cycle START indication |
| stopPulse | output | 1 | One-cycle STOP indication |
| busBusy | output | 1 | Bus held between START and STOP |
| arbLost | output | 1 | Sticky arbitration-lost flag |

## Verification
The bench first drives every pair of stable line states (clock, data) into every other pair, 16 transitions in all, each from a known busy state. This separates data movement with the clock high from movement with the clock low, and separates single-line changes from changes where both lines move together. The exact pulse latency and pulse width are measured on one START.

The arbitration flag is tried over all combinations of local drive and bus level at a clock rise, and with a low data line but no clock rise. The clear strobe is tested both alone and in the very cycle the set condition fires, which shows which of the two wins.

// File: rtl/busCondMon_pkg.sv
package busCondMon_pkg;

  // Strobes issued by the control logic to the datapath registers
  typedef struct packed {
    logic seenStart;
    logic seenStop;
    logic arbSet;
  } monStrb_t;

  // Synchronized line view handed from the datapath to the control logic
  typedef struct packed {
    logic sclNow;
    logic sclPrev;
    logic sdaNow;
    logic sdaPrev;
  } lineView_t;

endpackage

// File: rtl/busCondMonData.sv
module busCondMonData
  import busCondMon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      arbClear,
  input  monStrb_t  strb,
  output lineView_t view,
  output logic      startPulse,
  output logic      stopPulse,
  output logic      busBusy,
  output logic      arbLost
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclPipe;
  logic [LAST:0] sdaPipe;
  logic          sclPrev;
  logic          sdaPrev;

  // Synchronizer chain, reset to the idle-high level of the bus
  generate
    for (genvar st = 0; st < SYNC_STAGES; st++) begin : g_sync
      if (st == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sclPipe[0] <= 1'b1;
            sdaPipe[0] <= 1'b1;
          end else begin
            sclPipe[0] <= sclIn;
            sdaPipe[0] <= sdaIn;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sclPipe[st] <= 1'b1;
            sdaPipe[st] <= 1'b1;
          end else begin
            sclPipe[st] <= sclPipe[st-1];
            sdaPipe[st] <= sdaPipe[st-1];
          end
        end
      end
    end
  endgenerate

  // Previous synchronized sample for edge comparison
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclPipe[LAST];
      sdaPrev <= sdaPipe[LAST];
    end
  end

  always_comb begin
    view.sclNow  = sclPipe[LAST];
    view.sclPrev = sclPrev;
    view.sdaNow  = sdaPipe[LAST];
    view.sdaPrev = sdaPrev;
  end

  // Output registers driven by the control strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPulse <= 1'b0;
      stopPulse  <= 1'b0;
      busBusy    <= 1'b0;
      arbLost    <= 1'b0;
    end else begin
      startPulse <= strb.seenStart;
      stopPulse  <= strb.seenStop;
      if (strb.seenStart)     busBusy <= 1'b1;
      else if (strb.seenStop) busBusy <= 1'b0;
      if (strb.arbSet)        arbLost <= 1'b1;
      else if (arbClear)      arbLost <= 1'b0;
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse) else $error("start pulse longer than one cycle"); // R2
  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |=> !stopPulse) else $error("stop pulse longer than one cycle"); // R3
  AST_BUSY_WITH_START: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> busBusy) else $error("busy not set by start"); // R4
  AST_IDLE_WITH_STOP: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |-> !busBusy) else $error("busy not cleared by stop"); // R4
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!startPulse && !stopPulse) |-> $stable(busBusy)) else $error("busy moved without event"); // R4
  AST_ARB_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (arbLost && !arbClear) |=> arbLost) else $error("arb flag dropped without clear"); // R7
  AST_ARB_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (arbClear && !strb.arbSet) |=> !arbLost) else $error("arb flag not cleared"); // R9
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(startPulse && stopPulse)) else $error("start and stop together"); // R10

endmodule

// File: rtl/busCondMonCtrl.sv
module busCondMonCtrl
  import busCondMon_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  lineView_t view,
  input  logic      sdaDriveLow,
  output monStrb_t  strb
);

  logic sclSteadyHigh;
  logic sclRising;

  always_comb begin
    // Clock high in both samples: a data move here is a bus condition
    sclSteadyHigh  = view.sclNow && view.sclPrev;
    sclRising      = view.sclNow && !view.sclPrev;
    strb.seenStart = sclSteadyHigh && view.sdaPrev && !view.sdaNow;
    strb.seenStop  = sclSteadyHigh && !view.sdaPrev && view.sdaNow;
    // Released driver should read high at the clock rise
    strb.arbSet    = sclRising && !sdaDriveLow && !view.sdaNow;
  end

  AST_NO_DUAL_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.seenStart && strb.seenStop)) else $error("dual event strobe"); // R10
  AST_NO_COND_ON_SCL_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    (view.sclNow != view.sclPrev) |-> !(strb.seenStart || strb.seenStop)) else $error("condition on clock move"); // R6
  AST_NO_ARB_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rstN)
    sdaDriveLow |-> !strb.arbSet) else $error("arb set while driving"); // R8

endmodule

// File: rtl/busCondMon.sv
module busCondMon
  import busCondMon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic sdaDriveLow,
  input  logic arbClear,
  output logic startPulse,
  output logic stopPulse,
  output logic busBusy,
  output logic arbLost
);

  lineView_t view;
  monStrb_t  strb;

  busCondMonData #(.SYNC_STAGES(SYNC_STAGES)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .arbClear   (arbClear),
    .strb       (strb),
    .view       (view),
    .startPulse (startPulse),
    .stopPulse  (stopPulse),
    .busBusy    (busBusy),
    .arbLost    (arbLost)
  );

  busCondMonCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .view        (view),
    .sdaDriveLow (sdaDriveLow),
    .strb        (strb)
  );

endmodule

// File: tb/busCondMon_tb.sv
`timescale 1ns/1ps
module busCondMon_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1;
  logic sdaIn = 1'b1;
  logic sdaDriveLow = 1'b0;
  logic arbClear = 1'b0;
  logic startPulse, stopPulse, busBusy, arbLost;

  int total = 0;
  int bad = 0;
  int startCnt = 0;
  int stopCnt = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  busCondMon u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaDriveLow(sdaDriveLow), .arbClear(arbClear),
    .startPulse(startPulse), .stopPulse(stopPulse),
    .busBusy(busBusy), .arbLost(arbLost)
  );

  always @(negedge clk) begin
    if (startPulse) startCnt++;
    if (stopPulse)  stopCnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic d);
    @(negedge clk);
    sclIn <= c;
    sdaIn <= d;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN <= 1'b0;
    sclIn <= 1'b1; sdaIn <= 1'b1; sdaDriveLow <= 1'b0; arbClear <= 1'b0;
    repeat (3) @(negedge clk);
    rstN <= 1'b1;
    settle();
  endtask

  initial begin
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 start", int'(startPulse), 0);
    check("R1 stop", int'(stopPulse), 0);
    check("R1 busy", int'(busBusy), 0);
    check("R1 arb", int'(arbLost), 0);
    rstN <= 1'b1;
    settle();
    check("R1 busy idle", int'(busBusy), 0);

    // R2 exact latency and width of a START
    drive(1'b1, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    check("R2 pulse at edge 3", int'(startPulse), 1);
    check("R4 busy with start", int'(busBusy), 1);
    @(posedge clk); #1;
    check("R2 pulse one cycle", int'(startPulse), 0);

    // Exhaustive sweep of line transitions A -> B
    doReset();
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        logic ac, ad, bc, bd;
        int expStart, expStop, busyA, busyB;
        ac = a[1]; ad = a[0]; bc = b[1]; bd = b[0];
        doReset();
        drive(ac, ad);
        settle();
        busyA = (ac && !ad) ? 1 : 0;
        startCnt = 0; stopCnt = 0;
        drive(bc, bd);
        settle();
        expStart = (ac && bc && ad && !bd) ? 1 : 0;
        expStop  = (ac && bc && !ad && bd) ? 1 : 0;
        busyB = expStart ? 1 : (expStop ? 0 : busyA);
        // R2 R3 R5 R6: pulses only on data moves with clock steady high
        check($sformatf("R2/R5/R6 start %0d->%0d", a, b), startCnt, expStart);
        check($sformatf("R3/R5/R6 stop %0d->%0d", a, b), stopCnt, expStop);
        check($sformatf("R4 busy %0d->%0d", a, b), int'(busBusy), busyB);
      end
    end

    // R4 repeated START keeps busy; STOP while idle keeps idle
    doReset();
    drive(1'b1, 1'b0); drive(1'b0, 1'b0); drive(1'b0, 1'b1); settle();
    drive(1'b1, 1'b1); settle();
    startCnt = 0;
    drive(1'b1, 1'b0); settle();
    check("R4 repeated start pulse", startCnt, 1);
    check("R4 repeated start busy", int'(busBusy), 1);
    drive(1'b0, 1'b0); settle(); drive(1'b1, 1'b0); settle();
    stopCnt = 0;
    drive(1'b1, 1'b1); settle();
    check("R3 stop pulse", stopCnt, 1);
    check("R4 busy cleared", int'(busBusy), 0);
    drive(1'b1, 1'b0); settle(); drive(1'b1, 1'b1); settle();
    drive(1'b0, 1'b1); drive(1'b0, 1'b0); drive(1'b1, 1'b0); settle();
    drive(1'b1, 1'b1); settle();
    check("R4 busy after second stop", int'(busBusy), 0);

    // R7 R8: arbitration sweep over drive and bus level at a clock rise
    for (int oe = 0; oe < 2; oe++) begin
      for (int lv = 0; lv < 2; lv++) begin
        doReset();
        drive(1'b0, 1'b1); settle();
        @(negedge clk); sdaDriveLow <= oe[0]; sdaIn <= lv[0];
        settle();
        check($sformatf("R8 no set before rise oe=%0d lv=%0d", oe, lv), int'(arbLost), 0);
        drive(1'b1, lv[0]); settle();
        check($sformatf("R7/R8 arb oe=%0d lv=%0d", oe, lv), int'(arbLost), (oe == 0 && lv == 0) ? 1 : 0);
        drive(1'b0, 1'b1); settle();
        check($sformatf("R7 sticky oe=%0d lv=%0d", oe, lv), int'(arbLost), (oe == 0 && lv == 0) ? 1 : 0);
      end
    end

    // R8: low data with clock already high (no rise) does not set
    doReset();
    drive(1'b1, 1'b0); settle();
    check("R8 no rise no set", int'(arbLost), 0);

    // R9: clear alone
    doReset();
    drive(1'b0, 1'b0); settle(); drive(1'b1, 1'b0); settle();
    check("R7 set before clear", int'(arbLost), 1);
    @(negedge clk); arbClear <= 1'b1;
    @(negedge clk); arbClear <= 1'b0;
    check("R9 cleared", int'(arbLost), 0);

    // R9: clear in the same cycle as the set condition -> set wins
    drive(1'b0, 1'b0); settle();
    drive(1'b1, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk); arbClear <= 1'b1;
    @(negedge clk); arbClear <= 1'b0;
    check("R9 set wins over clear", int'(arbLost), 1);
    settle();
    check("R9 remains set", int'(arbLost), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule